// File: doc/BRIEF.md
# Memory Access Attribute Resolver

This block classifies each instruction fetch and data access and assigns the attributes that decide how the memory system handles it. The attributes are a cache mode, an on-chip SRAM hit flag, a write-protect flag, a write-mode flag and a write-violation flag. The request address goes through untouched. The block is driven from programmable windows: one SRAM window, four address regions with their own cache mode and write-protect bit, and a default setting that applies when nothing else matches.

Every request resolves to exactly one attribute source, and these sources play the role of states:

- SRC_SPECIAL: the access is special-mode. This covers interrupt acknowledge, control-register access, cache maintenance and debug operations.
- SRC_SRAM: the access hits the SRAM window.
- SRC_RGN_A: the access hits the first region of its chain. That is region 0 for data and region 2 for instructions.
- SRC_RGN_B: the access hits the second region of its chain. That is region 1 for data and region 3 for instructions.
- SRC_DEFAULT: nothing matched.

The transition into a source is taken in that priority order. A test-and-set override then acts on data results that come from a region or from the default. A parameter adds a register stage, so the result appears one cycle after the request.

Top module: `mar_attr_resolver`

## Requirements
- R1: The output address always equals the request address. With REG_OUT=1 it is the address captured with the request.
- R2: A special-mode request gets cache mode 2'b10 (non-cacheable, precise), write-protect 0 and violation 0, whatever the windows hold.
- R3: A special-mode request sets the SRAM hit flag only when all of these hold: it is an interrupt-acknowledge/emulator access, the mask input is 0, and the SRAM window matches. Any other special-mode request never hits the SRAM.
- R4: A normal data request takes its attributes from the first match in this order: SRAM window, region 0, region 1, then the default setting. Regions 2 and 3 have no effect on data.
- R5: A normal instruction request takes its attributes from the first match in this order: SRAM window, region 2, region 3, then the default setting. Regions 0 and 1 have no effect on instructions.
- R6: Region i matches when its enable bit is 1 and (addr & ~mask_i) == (base_i & ~mask_i). Bits set in the mask are don't-care. A disabled region never matches.
- R7: The SRAM window matches when its enable bit is 1 and the address bits above WIN_LOG2 equal the window base. A normal request that hits it gets SRAM hit 1, cache mode 2'b10 and write-protect 0.
- R8: A normal data request with the test-and-set flag that misses the SRAM window gets cache mode 2'b10. Its write-protect still comes from its region or the default. The flag has no effect on instruction requests.
- R9: The violation output is 1 exactly when all of these hold: the request is normal, the effective write-protect is 1, and the request is a write, a read-modify-write or a test-and-set.
- R10: The write-mode output (out_wthru) is 1 whenever the effective cache mode is not copyback (2'b00). The cache-mode encoding is 00 copyback, 01 write-through, 10 non-cacheable precise and 11 non-cacheable imprecise.
- R11: With REG_OUT=1, outputs are captured on a clock edge where req_valid is 1. out_valid is the registered req_valid. When req_valid is 0, the attributes and address hold. With REG_OUT=0, the outputs follow the inputs in the same cycle.
- R12: While rst_n is low, the registered outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW | Access address |
| req_is_instr | input | 1 | 1 for an instruction fetch, 0 for data |
| req_special | input | 1 | Special-mode access |
| req_iack_emu | input | 1 | Special access is an interrupt acknowledge or emulator operation |
| req_tas | input | 1 | Test-and-set data access |
| req_write | input | 1 | Write access |
| req_rmw | input | 1 | Read-modify-write access |
| csp_mask | input | 1 | Blocks SRAM hits for interrupt-acknowledge/emulator accesses |
| sram_en | input | 1 | SRAM window enable |
| sram_base | input | AW-WIN_LOG2 | SRAM window base (upper address bits) |
| rgn_en | input | 4 | Region enables |
| rgn_base | input | 4*AW | Region bases, region i at [i*AW +: AW] |
| rgn_mask | input | 4*AW | Region don't-care masks |
| rgn_cmode | input | 8 | Region cache modes, region i at [2i +: 2] |
| rgn_wp | input | 4 | Region write-protect bits |
| dflt_cmode | input | 2 | Default cache mode |
| dflt_wp | input | 1 | Default write-protect |
| out_valid | output | 1 | Result valid |
| out_addr | output | AW | Pass-through address |
| out_cmode | output | 2 | Effective cache mode |
| out_sram_hit | output | 1 | SRAM hit enable |
| out_wprot | output | 1 | Effective write-protect |
| out_wthru | output | 1 | Write mode: writes not held as copyback |
| out_violation | output | 1 | Write to a protected area |

## Verification
The bench builds two copies with AW=8 and WIN_LOG2=4, one with REG_OUT=1 and one with REG_OUT=0. With an 8-bit address, every address value can be swept under each of four window configurations and all 32 combinations of instruction, special, interrupt-acknowledge, mask and test-and-set flags. Those configurations cover overlapping regions, a region that overlaps the SRAM window, non-contiguous masks, a region that matches everything and all windows disabled. The registered copy is also checked for hold behaviour while req_valid is low and for its reset values.

// File: rtl/mar_pkg.sv
package mar_pkg;

    localparam int NUM_RGN = 4;

    typedef enum logic [1:0] {
        CM_COPYBACK     = 2'b00,
        CM_WTHRU        = 2'b01,
        CM_NC_PRECISE   = 2'b10,
        CM_NC_IMPRECISE = 2'b11
    } cmode_e;

    typedef enum logic [2:0] {
        SRC_SPECIAL,
        SRC_SRAM,
        SRC_RGN_A,
        SRC_RGN_B,
        SRC_DEFAULT
    } src_e;

    typedef struct packed {
        cmode_e cmode;
        logic   sram_hit;
        logic   wprot;
        logic   viol;
        logic   wthru;
    } attr_t;

endpackage

// File: rtl/mar_region_match.sv
module mar_region_match #(
    parameter int AW = 32
) (
    input  logic          en,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] mask,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    logic [AW-1:0] care;

    always_comb begin
        care = ~mask;
        hit  = en && ((addr & care) == (base & care));
    end
endmodule

// File: rtl/mar_sram_match.sv
module mar_sram_match #(
    parameter int AW       = 32,
    parameter int WIN_LOG2 = 12
) (
    input  logic                   en,
    input  logic [AW-WIN_LOG2-1:0] base,
    input  logic [AW-1:0]          addr,
    output logic                   hit
);
    localparam int TAG_W = AW - WIN_LOG2;

    logic [TAG_W-1:0] tag;
    logic             unused_low;

    always_comb begin
        tag        = addr[AW-1:WIN_LOG2];
        unused_low = ^addr[WIN_LOG2-1:0];
        hit        = en && (tag == base);
    end
endmodule

// File: rtl/mar_attr_select.sv
module mar_attr_select
    import mar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vld,
    input  logic       is_instr,
    input  logic       special,
    input  logic       iack_emu,
    input  logic       csp_mask,
    input  logic       tas,
    input  logic       write,
    input  logic       rmw,
    input  logic       sram_match,
    input  logic [3:0] rgn_hit,
    input  logic [7:0] rgn_cmode,
    input  logic [3:0] rgn_wp,
    input  logic [1:0] dflt_cmode,
    input  logic       dflt_wp,
    output attr_t      attr,
    output src_e       src
);
    logic       a_hit, b_hit, a_wp, b_wp;
    logic [1:0] a_cm, b_cm;
    logic       tas_data;

    // chain selection: data uses regions 0/1, instructions regions 2/3
    always_comb begin
        a_hit = is_instr ? rgn_hit[2]     : rgn_hit[0];
        b_hit = is_instr ? rgn_hit[3]     : rgn_hit[1];
        a_cm  = is_instr ? rgn_cmode[5:4] : rgn_cmode[1:0];
        b_cm  = is_instr ? rgn_cmode[7:6] : rgn_cmode[3:2];
        a_wp  = is_instr ? rgn_wp[2]      : rgn_wp[0];
        b_wp  = is_instr ? rgn_wp[3]      : rgn_wp[1];
    end

    // source decision in priority order
    always_comb begin
        if (special)         src = SRC_SPECIAL;
        else if (sram_match) src = SRC_SRAM;
        else if (a_hit)      src = SRC_RGN_A;
        else if (b_hit)      src = SRC_RGN_B;
        else                 src = SRC_DEFAULT;
    end

    // attributes for the chosen source
    always_comb begin
        attr       = '0;
        tas_data   = tas && !is_instr;
        unique case (src)
            SRC_SPECIAL: begin
                attr.cmode    = CM_NC_PRECISE;
                attr.sram_hit = sram_match && iack_emu && !csp_mask;
                attr.wprot    = 1'b0;
            end
            SRC_SRAM: begin
                attr.cmode    = CM_NC_PRECISE;
                attr.sram_hit = 1'b1;
                attr.wprot    = 1'b0;
            end
            SRC_RGN_A: begin
                attr.cmode = tas_data ? CM_NC_PRECISE : cmode_e'(a_cm);
                attr.wprot = a_wp;
            end
            SRC_RGN_B: begin
                attr.cmode = tas_data ? CM_NC_PRECISE : cmode_e'(b_cm);
                attr.wprot = b_wp;
            end
            SRC_DEFAULT: begin
                attr.cmode = tas_data ? CM_NC_PRECISE : cmode_e'(dflt_cmode);
                attr.wprot = dflt_wp;
            end
            default: attr.cmode = CM_NC_PRECISE;
        endcase
        attr.viol  = (src != SRC_SPECIAL) && attr.wprot && (write || rmw || tas);
        attr.wthru = (attr.cmode != CM_COPYBACK);
    end

    AST_SPECIAL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && special) |-> (attr.cmode == CM_NC_PRECISE && !attr.wprot && !attr.viol)); // R2

    AST_SPECIAL_SRAM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && special && (csp_mask || !iack_emu)) |-> !attr.sram_hit); // R3

    AST_SRAM_HIT_NC: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && attr.sram_hit) |-> (attr.cmode == CM_NC_PRECISE)); // R7

    AST_TAS_NC: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && tas && !is_instr && !special) |-> (attr.cmode == CM_NC_PRECISE)); // R8

    AST_WTHRU_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && attr.cmode == CM_COPYBACK) |-> !attr.wthru); // R10

endmodule

// File: rtl/mar_attr_resolver.sv
module mar_attr_resolver
    import mar_pkg::*;
#(
    parameter int AW       = 32,
    parameter int WIN_LOG2 = 12,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [AW-1:0]          req_addr,
    input  logic                   req_is_instr,
    input  logic                   req_special,
    input  logic                   req_iack_emu,
    input  logic                   req_tas,
    input  logic                   req_write,
    input  logic                   req_rmw,
    input  logic                   csp_mask,
    input  logic                   sram_en,
    input  logic [AW-WIN_LOG2-1:0] sram_base,
    input  logic [NUM_RGN-1:0]     rgn_en,
    input  logic [NUM_RGN*AW-1:0]  rgn_base,
    input  logic [NUM_RGN*AW-1:0]  rgn_mask,
    input  logic [2*NUM_RGN-1:0]   rgn_cmode,
    input  logic [NUM_RGN-1:0]     rgn_wp,
    input  logic [1:0]             dflt_cmode,
    input  logic                   dflt_wp,
    output logic                   out_valid,
    output logic [AW-1:0]          out_addr,
    output logic [1:0]             out_cmode,
    output logic                   out_sram_hit,
    output logic                   out_wprot,
    output logic                   out_wthru,
    output logic                   out_violation
);
    logic [NUM_RGN-1:0] rgn_hit;
    logic               sram_match;
    attr_t              attr;
    src_e               src;

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        mar_region_match #(.AW(AW)) u_match (
            .en   (rgn_en[g]),
            .base (rgn_base[g*AW +: AW]),
            .mask (rgn_mask[g*AW +: AW]),
            .addr (req_addr),
            .hit  (rgn_hit[g])
        );
    end

    mar_sram_match #(.AW(AW), .WIN_LOG2(WIN_LOG2)) u_sram (
        .en   (sram_en),
        .base (sram_base),
        .addr (req_addr),
        .hit  (sram_match)
    );

    mar_attr_select u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld        (req_valid),
        .is_instr   (req_is_instr),
        .special    (req_special),
        .iack_emu   (req_iack_emu),
        .csp_mask   (csp_mask),
        .tas        (req_tas),
        .write      (req_write),
        .rmw        (req_rmw),
        .sram_match (sram_match),
        .rgn_hit    (rgn_hit),
        .rgn_cmode  (rgn_cmode),
        .rgn_wp     (rgn_wp),
        .dflt_cmode (dflt_cmode),
        .dflt_wp    (dflt_wp),
        .attr       (attr),
        .src        (src)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_valid     <= 1'b0;
                out_addr      <= '0;
                out_cmode     <= '0;
                out_sram_hit  <= 1'b0;
                out_wprot     <= 1'b0;
                out_wthru     <= 1'b0;
                out_violation <= 1'b0;
            end else begin
                out_valid <= req_valid;
                if (req_valid) begin
                    out_addr      <= req_addr;
                    out_cmode     <= attr.cmode;
                    out_sram_hit  <= attr.sram_hit;
                    out_wprot     <= attr.wprot;
                    out_wthru     <= attr.wthru;
                    out_violation <= attr.viol;
                end
            end
        end

        AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |=> out_valid); // R11

        AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid |=> ($stable(out_cmode) && $stable(out_addr) && $stable(out_violation))); // R11

        AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |=> (out_addr == $past(req_addr))); // R1
    end else begin : g_comb
        always_comb begin
            out_valid     = req_valid;
            out_addr      = req_addr;
            out_cmode     = attr.cmode;
            out_sram_hit  = attr.sram_hit;
            out_wprot     = attr.wprot;
            out_wthru     = attr.wthru;
            out_violation = attr.viol;
        end

        AST_COMB_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |-> (out_addr == req_addr)); // R1
    end

    AST_SPECIAL_NO_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && src == SRC_SPECIAL) |-> !attr.viol); // R9

endmodule

// File: tb/tb_mar_attr_resolver.sv
module tb_mar_attr_resolver;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int WL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_is_instr = 1'b0, req_special = 1'b0, req_iack_emu = 1'b0;
    logic          req_tas = 1'b0, req_write = 1'b0, req_rmw = 1'b0, csp_mask = 1'b0;
    logic          sram_en = 1'b0;
    logic [AW-WL-1:0] sram_base = '0;
    logic          c_en [4];
    logic [AW-1:0] c_base [4];
    logic [AW-1:0] c_mask [4];
    logic [1:0]    c_cm [4];
    logic          c_wp [4];
    logic [1:0]    dflt_cmode = '0;
    logic          dflt_wp = 1'b0;

    logic [3:0]    rgn_en, rgn_wp;
    logic [4*AW-1:0] rgn_base, rgn_mask;
    logic [7:0]    rgn_cmode;
    assign rgn_en    = {c_en[3], c_en[2], c_en[1], c_en[0]};
    assign rgn_wp    = {c_wp[3], c_wp[2], c_wp[1], c_wp[0]};
    assign rgn_base  = {c_base[3], c_base[2], c_base[1], c_base[0]};
    assign rgn_mask  = {c_mask[3], c_mask[2], c_mask[1], c_mask[0]};
    assign rgn_cmode = {c_cm[3], c_cm[2], c_cm[1], c_cm[0]};

    logic          r_valid, c_valid;
    logic [AW-1:0] r_addr, c_addr;
    logic [1:0]    r_cm, c_cm_o;
    logic          r_sh, r_wp, r_wt, r_vi, c_sh, c_wp_o, c_wt, c_vi;

    mar_attr_resolver #(.AW(AW), .WIN_LOG2(WL), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_is_instr(req_is_instr), .req_special(req_special), .req_iack_emu(req_iack_emu),
        .req_tas(req_tas), .req_write(req_write), .req_rmw(req_rmw), .csp_mask(csp_mask),
        .sram_en(sram_en), .sram_base(sram_base), .rgn_en(rgn_en), .rgn_base(rgn_base),
        .rgn_mask(rgn_mask), .rgn_cmode(rgn_cmode), .rgn_wp(rgn_wp),
        .dflt_cmode(dflt_cmode), .dflt_wp(dflt_wp),
        .out_valid(r_valid), .out_addr(r_addr), .out_cmode(r_cm), .out_sram_hit(r_sh),
        .out_wprot(r_wp), .out_wthru(r_wt), .out_violation(r_vi));

    mar_attr_resolver #(.AW(AW), .WIN_LOG2(WL), .REG_OUT(1'b0)) dut_comb (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_is_instr(req_is_instr), .req_special(req_special), .req_iack_emu(req_iack_emu),
        .req_tas(req_tas), .req_write(req_write), .req_rmw(req_rmw), .csp_mask(csp_mask),
        .sram_en(sram_en), .sram_base(sram_base), .rgn_en(rgn_en), .rgn_base(rgn_base),
        .rgn_mask(rgn_mask), .rgn_cmode(rgn_cmode), .rgn_wp(rgn_wp),
        .dflt_cmode(dflt_cmode), .dflt_wp(dflt_wp),
        .out_valid(c_valid), .out_addr(c_addr), .out_cmode(c_cm_o), .out_sram_hit(c_sh),
        .out_wprot(c_wp_o), .out_wthru(c_wt), .out_violation(c_vi));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (addr %h instr %b special %b tas %b)",
                     req, act, exp, req_addr, req_is_instr, req_special, req_tas);
        end
    endtask

    function automatic bit rhit(input int i, input logic [AW-1:0] a);
        return c_en[i] && ((a & ~c_mask[i]) == (c_base[i] & ~c_mask[i]));
    endfunction

    // packed expectation: {valid, addr[7:0], 1'b0, cm[1:0], sram, wp, viol, wthru}
    function automatic logic [15:0] expect_out();
        logic [1:0] cm;
        logic sh, wp, sm, vi;
        int ia;
        sm = sram_en && (req_addr[AW-1:WL] == sram_base);
        sh = 1'b0;
        wp = 1'b0;
        if (req_special) begin
            cm = 2'b10;
            sh = sm && req_iack_emu && !csp_mask;
        end else if (sm) begin
            cm = 2'b10;
            sh = 1'b1;
        end else begin
            ia = req_is_instr ? 2 : 0;
            if (rhit(ia, req_addr)) begin
                cm = c_cm[ia]; wp = c_wp[ia];
            end else if (rhit(ia + 1, req_addr)) begin
                cm = c_cm[ia + 1]; wp = c_wp[ia + 1];
            end else begin
                cm = dflt_cmode; wp = dflt_wp;
            end
            if (req_tas && !req_is_instr) cm = 2'b10;
        end
        vi = !req_special && wp && (req_write || req_rmw || req_tas);
        return {1'b1, req_addr, 1'b0, cm, sh, wp, vi, (cm != 2'b00)};
    endfunction

    function automatic string tag_of();
        if (req_special) return "R2/R3/R9";
        if (sram_en && (req_addr[AW-1:WL] == sram_base)) return "R7/R9/R10";
        if (req_tas && !req_is_instr) return "R8/R9";
        if (req_is_instr) return "R5/R6/R10";
        return "R4/R6/R9/R10";
    endfunction

    task automatic set_cfg(input int k);
        for (int i = 0; i < 4; i++) begin
            c_en[i] = 1'b0; c_base[i] = '0; c_mask[i] = '0; c_cm[i] = '0; c_wp[i] = 1'b0;
        end
        case (k)
            0: begin
                sram_en = 1'b1; sram_base = 4'h4;
                c_en[0] = 1'b1; c_base[0] = 8'h00; c_mask[0] = 8'h3F; c_cm[0] = 2'b01; c_wp[0] = 1'b1;
                c_en[1] = 1'b1; c_base[1] = 8'h00; c_mask[1] = 8'h7F; c_cm[1] = 2'b11;
                c_en[2] = 1'b1; c_base[2] = 8'h80; c_mask[2] = 8'h0F; c_cm[2] = 2'b00; c_wp[2] = 1'b1;
                c_en[3] = 1'b1; c_base[3] = 8'h80; c_mask[3] = 8'h7F; c_cm[3] = 2'b01;
                dflt_cmode = 2'b00; dflt_wp = 1'b0;
            end
            1: begin
                sram_en = 1'b0; sram_base = 4'h0;
                c_base[0] = 8'h00; c_mask[0] = 8'hFF; c_cm[0] = 2'b01; c_wp[0] = 1'b1;
                dflt_cmode = 2'b11; dflt_wp = 1'b1;
            end
            2: begin
                sram_en = 1'b1; sram_base = 4'hF;
                c_en[0] = 1'b1; c_base[0] = 8'hF0; c_mask[0] = 8'h0F; c_cm[0] = 2'b00; c_wp[0] = 1'b1;
                c_en[2] = 1'b1; c_base[2] = 8'hA5; c_mask[2] = 8'h00; c_cm[2] = 2'b11; c_wp[2] = 1'b1;
                c_en[3] = 1'b1; c_base[3] = 8'h00; c_mask[3] = 8'hFF; c_cm[3] = 2'b00;
                dflt_cmode = 2'b01; dflt_wp = 1'b1;
            end
            default: begin
                sram_en = 1'b1; sram_base = 4'h0;
                c_en[0] = 1'b1; c_base[0] = 8'h52; c_mask[0] = 8'h30; c_cm[0] = 2'b01;
                c_en[1] = 1'b1; c_base[1] = 8'h00; c_mask[1] = 8'hFF; c_cm[1] = 2'b00; c_wp[1] = 1'b1;
                c_en[2] = 1'b1; c_base[2] = 8'h52; c_mask[2] = 8'h30; c_cm[2] = 2'b11; c_wp[2] = 1'b1;
                dflt_cmode = 2'b10; dflt_wp = 1'b0;
            end
        endcase
    endtask

    initial begin
        logic [15:0] exp_v, last_v;
        set_cfg(0);
        last_v = '0;
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state of registered outputs
        chk({r_valid, r_addr, r_cm, r_sh, r_wp, r_wt, r_vi} == '0, "R12",
            {1'b0, r_valid, r_addr, r_cm, r_sh, r_wp, r_wt, r_vi}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            set_cfg(k);
            for (int f = 0; f < 32; f++) begin
                for (int a = 0; a < 256; a++) begin
                    @(negedge clk);
                    req_valid    = 1'b1;
                    req_addr     = a[7:0];
                    req_is_instr = f[0];
                    req_special  = f[1];
                    req_iack_emu = f[2];
                    csp_mask     = f[3];
                    req_tas      = f[4];
                    req_write    = a[0] ^ f[2];
                    req_rmw      = a[1] & a[5];
                    #1;
                    exp_v = expect_out();
                    // R1 and attribute rules, same-cycle copy (R11 REG_OUT=0)
                    chk({c_valid, c_addr, 1'b0, c_cm_o, c_sh, c_wp_o, c_vi, c_wt} == exp_v,
                        {"R1/R11 comb ", tag_of()},
                        {c_valid, c_addr, 1'b0, c_cm_o, c_sh, c_wp_o, c_vi, c_wt}, exp_v);
                    @(posedge clk);
                    #1;
                    // R11 registered copy one cycle later
                    chk({r_valid, r_addr, 1'b0, r_cm, r_sh, r_wp, r_vi, r_wt} == exp_v,
                        {"R1/R11 reg ", tag_of()},
                        {r_valid, r_addr, 1'b0, r_cm, r_sh, r_wp, r_vi, r_wt}, exp_v);
                    last_v = exp_v;
                end
            end
        end
        // R11: hold with req_valid low while inputs change
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_addr  = 8'h3C + h[7:0];
            req_special = h[0];
            req_tas = 1'b1;
            #1;
            chk(c_valid == 1'b0, "R11 comb valid low", {15'd0, c_valid}, 16'h0000);
            @(posedge clk);
            #1;
            chk({1'b1, r_addr, 1'b0, r_cm, r_sh, r_wp, r_vi, r_wt} == last_v && !r_valid,
                "R11 hold", {r_valid, r_addr, 1'b0, r_cm, r_sh, r_wp, r_vi, r_wt}, last_v & 16'h7FFF);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule